// File: doc/BRIEF.md
# Runahead Mode Controller

This block decides when a core stops waiting on a long memory miss and runs ahead instead. When the load at the oldest slot of the retirement window misses in the second-level cache, the controller saves the architectural register file, the branch-history register and a snapshot of the return-address stack. It records the load's PC and marks the load's destination register invalid. The pipeline then keeps fetching and retiring. Every retiring instruction has its destination invalid bit recomputed from the invalid bits of its sources. An instruction with an invalid source is flagged to be retired without executing, and no store becomes visible outside the core.

When the memory system reports that the missing data has arrived, the controller waits a fixed fill window, LEAD cycles. In one exit cycle it then flushes the pipeline, restores the saved state, redirects fetch to the saved load PC and clears every invalid bit. If the early-restart input is high when the data arrives, the exit cycle comes first and the fill window runs afterwards. The refetch therefore starts LEAD cycles sooner. In both cases the fill-done pulse falls in the same cycle.

States: NORMAL (architectural execution), RUNAHEAD (speculative retirement), FILL (miss data arriving, still speculative), EXIT (one cycle of flush, restore and redirect) and DRAIN (architectural again, waiting out the fill window after an early exit). Transitions: NORMAL→RUNAHEAD on a head miss; RUNAHEAD→FILL on arrival with early restart low; RUNAHEAD→EXIT on arrival with early restart high; FILL→EXIT when the window counter expires; EXIT→NORMAL after a normal exit; EXIT→DRAIN after an early exit; DRAIN→NORMAL when the window counter expires. A head miss takes the retire slot of its cycle, so a retire offered in the same cycle is dropped. Retires offered during EXIT are dropped as flushed.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the block is in NORMAL with runahead_mode, ckpt_save, flush, redirect_valid, ckpt_restore and fill_done all low, every register reading 0, and every invalid bit clear.
- R2: A head_miss in NORMAL raises ckpt_save in that same cycle, raises runahead_mode from the next cycle, and sets the invalid bit of head_rd.
- R3: During RUNAHEAD or FILL, a retire in which any used source (rs1 or rs2) is invalid raises retire_skip in its cycle. It also sets the destination's invalid bit and leaves the destination's value unchanged.
- R4: During RUNAHEAD or FILL, a retire whose used sources are all valid (or that uses no source) writes its data and clears the destination's invalid bit.
- R5: store_commit is high only for a retiring store outside runahead (NORMAL or DRAIN), never while runahead_mode is high.
- R6: A head_miss while already in runahead does not raise ckpt_save and does not change redirect_pc, but it does set the invalid bit of its head_rd.
- R7: With early_en low at arrival, runahead_mode stays high and flush stays low for LEAD cycles after the miss_arrive cycle. The next cycle is a single EXIT cycle, in which flush, ckpt_restore, redirect_valid and fill_done are all high, redirect_pc is the triggering load's PC, and bhr_restore and ras_restore are the values saved at entry.
- R8: From the cycle after EXIT, every register reads its value from before entry and all invalid bits are clear.
- R9: With early_en high at arrival, EXIT (flush and redirect) occurs in the very next cycle with fill_done low. fill_done pulses alone LEAD cycles after that, LEAD+1 cycles after arrival.
- R10: miss_arrive while in NORMAL is ignored: no flush, no redirect and no mode change follows.
- R11: In NORMAL, a retire writes its destination, retire_skip stays low, and the invalid bits stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_miss | input | 1 | Oldest load missed in the second-level cache |
| head_pc | input | PC_W | PC of that load |
| head_rd | input | log2(NREG) | Destination register of that load |
| miss_arrive | input | 1 | Stalled miss data has arrived |
| early_en | input | 1 | Early restart, sampled together with miss_arrive |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_store | input | 1 | Retiring instruction is a store |
| retire_rd_we | input | 1 | Retiring instruction writes a register |
| retire_rd | input | log2(NREG) | Destination register |
| retire_rs1_use | input | 1 | First source is used |
| retire_rs1 | input | log2(NREG) | First source register |
| retire_rs2_use | input | 1 | Second source is used |
| retire_rs2 | input | log2(NREG) | Second source register |
| retire_wdata | input | XLEN | Result value |
| bhr_in | input | BHR_W | Current branch-history register |
| ras_in | input | RAS_W | Current return-stack snapshot |
| rf_rd_addr | input | log2(NREG) | Register read address |
| rf_rd_data | output | XLEN | Register read data |
| rf_rd_inv | output | 1 | Invalid bit of the read register |
| runahead_mode | output | 1 | High in RUNAHEAD, FILL and EXIT |
| ckpt_save | output | 1 | Checkpoint taken this cycle |
| ckpt_restore | output | 1 | Checkpoint restored at the end of this cycle |
| flush | output | 1 | Flush all in-flight instructions |
| redirect_valid | output | 1 | Redirect fetch to redirect_pc |
| redirect_pc | output | PC_W | Saved PC of the triggering load |
| bhr_restore | output | BHR_W | Saved branch history |
| ras_restore | output | RAS_W | Saved return-stack snapshot |
| retire_skip | output | 1 | Retiring instruction has an invalid source |
| store_commit | output | 1 | Retiring store becomes visible |
| fill_done | output | 1 | Miss data marked returned |

## Verification
On every cycle the assertions check the following. A checkpoint is only taken from NORMAL and always leads into runahead. Skips and visible stores never occur in the wrong mode. The restart PC holds steady for the whole runahead episode. EXIT lasts one cycle and carries flush, restore and redirect together. No invalid bit can be seen outside runahead, and an arrival outside runahead never causes a flush. The bench scenarios cover what a per-cycle property cannot show. These are the exact LEAD-cycle spacing of exit and fill-done in the normal and early orders, the register values restored after speculative writes, invalid propagation through chains of retires including clearing by an immediate move, and the saved history values presented at exit.

// File: rtl/runahead_pkg.sv
package runahead_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_RUNAHEAD,
        ST_FILL,
        ST_EXIT,
        ST_DRAIN
    } ra_state_e;

endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
    import runahead_pkg::*;
#(
    parameter int LEAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_miss,
    input  logic miss_arrive,
    input  logic early_en,
    output logic ckpt_save,
    output logic restore,
    output logic track,
    output logic arch_wr,
    output logic mark_miss,
    output logic fill_done,
    output logic ra_mode
);

    localparam int CNT_W = (LEAD < 2) ? 1 : $clog2(LEAD + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LEAD - 1);

    ra_state_e        state, state_nx;
    logic [CNT_W-1:0] win_cnt;
    logic             early_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORMAL:   if (head_miss) state_nx = ST_RUNAHEAD;
            ST_RUNAHEAD: if (miss_arrive) state_nx = early_en ? ST_EXIT : ST_FILL;
            ST_FILL:     if (win_cnt == '0) state_nx = ST_EXIT;
            ST_EXIT:     state_nx = early_q ? ST_DRAIN : ST_NORMAL;
            ST_DRAIN:    if (win_cnt == '0) state_nx = ST_NORMAL;
            default:     state_nx = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_NORMAL;
            win_cnt <= '0;
            early_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_RUNAHEAD && miss_arrive) begin
                early_q <= early_en;
                win_cnt <= CNT_LOAD;
            end else if (state == ST_EXIT) begin
                win_cnt <= CNT_LOAD;
            end else if ((state == ST_FILL || state == ST_DRAIN) && win_cnt != '0) begin
                win_cnt <= win_cnt - 1'b1;
            end
        end
    end

    always_comb begin
        ckpt_save = 1'b0;
        restore   = 1'b0;
        track     = 1'b0;
        arch_wr   = 1'b0;
        mark_miss = 1'b0;
        fill_done = 1'b0;
        ra_mode   = 1'b0;
        unique case (state)
            ST_NORMAL: begin
                arch_wr   = 1'b1;
                ckpt_save = head_miss;
                mark_miss = head_miss;
            end
            ST_RUNAHEAD, ST_FILL: begin
                track     = 1'b1;
                ra_mode   = 1'b1;
                mark_miss = head_miss;
            end
            ST_EXIT: begin
                ra_mode   = 1'b1;
                restore   = 1'b1;
                fill_done = !early_q;
            end
            ST_DRAIN: begin
                arch_wr   = 1'b1;
                fill_done = (win_cnt == '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ra_inv_track.sv
module ra_inv_track #(
    parameter int NREG = 16,
    localparam int AW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_all,
    input  logic          track,
    input  logic          mark_miss,
    input  logic [AW-1:0] miss_rd,
    input  logic          ret_en,
    input  logic          ret_rd_we,
    input  logic [AW-1:0] ret_rd,
    input  logic          rs1_use,
    input  logic [AW-1:0] rs1,
    input  logic          rs2_use,
    input  logic [AW-1:0] rs2,
    input  logic [AW-1:0] rd_addr,
    output logic          dst_inv,
    output logic          rd_inv
);

    logic [NREG-1:0] inv;

    assign dst_inv = (rs1_use && inv[rs1]) || (rs2_use && inv[rs2]);
    assign rd_inv  = inv[rd_addr];

    for (genvar i = 0; i < NREG; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                inv[i] <= 1'b0;
            end else if (mark_miss && miss_rd == AW'(i)) begin
                inv[i] <= 1'b1;
            end else if (track && ret_en && ret_rd_we && ret_rd == AW'(i)) begin
                inv[i] <= dst_inv;
            end
        end
    end

endmodule

// File: rtl/ra_regfile_ckpt.sv
module ra_regfile_ckpt #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save,
    input  logic            restore,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] work [NREG];
    logic [XLEN-1:0] shadow [NREG];

    assign rdata = work[raddr];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                work[i]   <= '0;
                shadow[i] <= '0;
            end else begin
                if (save) shadow[i] <= work[i];
                if (restore) begin
                    work[i] <= shadow[i];
                end else if (we && waddr == AW'(i)) begin
                    work[i] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/ra_ctx_ckpt.sv
module ra_ctx_ckpt #(
    parameter int PC_W  = 32,
    parameter int BHR_W = 16,
    parameter int RAS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [BHR_W-1:0] bhr_in,
    input  logic [RAS_W-1:0] ras_in,
    output logic [PC_W-1:0]  pc_q,
    output logic [BHR_W-1:0] bhr_q,
    output logic [RAS_W-1:0] ras_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            bhr_q <= '0;
            ras_q <= '0;
        end else if (save) begin
            pc_q  <= pc_in;
            bhr_q <= bhr_in;
            ras_q <= ras_in;
        end
    end

endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl #(
    parameter int NREG  = 16,
    parameter int XLEN  = 32,
    parameter int PC_W  = 32,
    parameter int BHR_W = 16,
    parameter int RAS_W = 32,
    parameter int LEAD  = 4,
    localparam int AW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_miss,
    input  logic [PC_W-1:0]  head_pc,
    input  logic [AW-1:0]    head_rd,
    input  logic             miss_arrive,
    input  logic             early_en,
    input  logic             retire_valid,
    input  logic             retire_store,
    input  logic             retire_rd_we,
    input  logic [AW-1:0]    retire_rd,
    input  logic             retire_rs1_use,
    input  logic [AW-1:0]    retire_rs1,
    input  logic             retire_rs2_use,
    input  logic [AW-1:0]    retire_rs2,
    input  logic [XLEN-1:0]  retire_wdata,
    input  logic [BHR_W-1:0] bhr_in,
    input  logic [RAS_W-1:0] ras_in,
    input  logic [AW-1:0]    rf_rd_addr,
    output logic [XLEN-1:0]  rf_rd_data,
    output logic             rf_rd_inv,
    output logic             runahead_mode,
    output logic             ckpt_save,
    output logic             ckpt_restore,
    output logic             flush,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic [BHR_W-1:0] bhr_restore,
    output logic [RAS_W-1:0] ras_restore,
    output logic             retire_skip,
    output logic             store_commit,
    output logic             fill_done
);

    logic restore, track, arch_wr, mark_miss, dst_inv, ret_en, rf_we;

    assign ret_en = retire_valid && !head_miss;

    ra_mode_fsm #(.LEAD(LEAD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_miss   (head_miss),
        .miss_arrive (miss_arrive),
        .early_en    (early_en),
        .ckpt_save   (ckpt_save),
        .restore     (restore),
        .track       (track),
        .arch_wr     (arch_wr),
        .mark_miss   (mark_miss),
        .fill_done   (fill_done),
        .ra_mode     (runahead_mode)
    );

    ra_inv_track #(.NREG(NREG)) u_inv (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (restore),
        .track     (track),
        .mark_miss (mark_miss),
        .miss_rd   (head_rd),
        .ret_en    (ret_en),
        .ret_rd_we (retire_rd_we),
        .ret_rd    (retire_rd),
        .rs1_use   (retire_rs1_use),
        .rs1       (retire_rs1),
        .rs2_use   (retire_rs2_use),
        .rs2       (retire_rs2),
        .rd_addr   (rf_rd_addr),
        .dst_inv   (dst_inv),
        .rd_inv    (rf_rd_inv)
    );

    assign rf_we = ret_en && retire_rd_we && (arch_wr || (track && !dst_inv));

    ra_regfile_ckpt #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .save    (ckpt_save),
        .restore (restore),
        .we      (rf_we),
        .waddr   (retire_rd),
        .wdata   (retire_wdata),
        .raddr   (rf_rd_addr),
        .rdata   (rf_rd_data)
    );

    ra_ctx_ckpt #(.PC_W(PC_W), .BHR_W(BHR_W), .RAS_W(RAS_W)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .save   (ckpt_save),
        .pc_in  (head_pc),
        .bhr_in (bhr_in),
        .ras_in (ras_in),
        .pc_q   (redirect_pc),
        .bhr_q  (bhr_restore),
        .ras_q  (ras_restore)
    );

    assign ckpt_restore   = restore;
    assign flush          = restore;
    assign redirect_valid = restore;
    assign retire_skip    = ret_en && track && dst_inv;
    assign store_commit   = ret_en && retire_store && arch_wr;

endmodule

// File: rtl/ra_ctrl_checker.sv
module ra_ctrl_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            runahead_mode,
    input logic            ckpt_save,
    input logic            ckpt_restore,
    input logic            flush,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_pc,
    input logic            retire_skip,
    input logic            store_commit,
    input logic            rf_rd_inv,
    input logic            miss_arrive
);

    p_save_from_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |-> !runahead_mode);

    p_save_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |=> runahead_mode);

    p_skip_in_runahead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        retire_skip |-> (runahead_mode && !flush));

    p_no_visible_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        store_commit |-> !runahead_mode);

    p_restart_pc_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (runahead_mode && $past(runahead_mode)) |-> $stable(redirect_pc));

    p_exit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!flush && !runahead_mode));

    p_exit_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (redirect_valid && ckpt_restore && runahead_mode));

    p_inv_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !runahead_mode |-> !rf_rd_inv);

    p_arrive_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!runahead_mode && miss_arrive) |=> !flush);

endmodule

bind runahead_ctrl ra_ctrl_checker #(.PC_W(PC_W)) u_ra_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .runahead_mode  (runahead_mode),
    .ckpt_save      (ckpt_save),
    .ckpt_restore   (ckpt_restore),
    .flush          (flush),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .retire_skip    (retire_skip),
    .store_commit   (store_commit),
    .rf_rd_inv      (rf_rd_inv),
    .miss_arrive    (miss_arrive)
);

// File: tb/test_runahead_ctrl.sv
`timescale 1ns/100ps
module test_runahead_ctrl;

    localparam int NREG = 16, XLEN = 32, PC_W = 32, BHR_W = 16, RAS_W = 32, LEAD = 4;
    localparam int AW = $clog2(NREG);

    localparam int S_MODE = 0, S_SAVE = 1, S_FLUSH = 2, S_REDIR = 3, S_RPC = 4,
                   S_FILL = 5, S_SKIP = 6, S_STORE = 7, S_RDATA = 8, S_RINV = 9,
                   S_BHR = 10, S_RAS = 11, S_REST = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic head_miss, miss_arrive, early_en;
    logic [PC_W-1:0] head_pc;
    logic [AW-1:0] head_rd, retire_rd, retire_rs1, retire_rs2, rf_rd_addr;
    logic retire_valid, retire_store, retire_rd_we, retire_rs1_use, retire_rs2_use;
    logic [XLEN-1:0] retire_wdata, rf_rd_data;
    logic [BHR_W-1:0] bhr_in, bhr_restore;
    logic [RAS_W-1:0] ras_in, ras_restore;
    logic rf_rd_inv, runahead_mode, ckpt_save, ckpt_restore, flush, redirect_valid;
    logic retire_skip, store_commit, fill_done;
    logic [PC_W-1:0] redirect_pc;

    always #2.5 clk = ~clk;

    runahead_ctrl #(.NREG(NREG), .XLEN(XLEN), .PC_W(PC_W), .BHR_W(BHR_W),
                    .RAS_W(RAS_W), .LEAD(LEAD)) i_runahead_ctrl (.*);

    typedef struct {
        int          stamp;
        int          sig;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] get_sig(int s);
        case (s)
            S_MODE:  return 32'(runahead_mode);
            S_SAVE:  return 32'(ckpt_save);
            S_FLUSH: return 32'(flush);
            S_REDIR: return 32'(redirect_valid);
            S_RPC:   return redirect_pc;
            S_FILL:  return 32'(fill_done);
            S_SKIP:  return 32'(retire_skip);
            S_STORE: return 32'(store_commit);
            S_RDATA: return rf_rd_data;
            S_RINV:  return 32'(rf_rd_inv);
            S_BHR:   return 32'(bhr_restore);
            S_RAS:   return ras_restore;
            S_REST:  return 32'(ckpt_restore);
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    // monitor: pops expectations stamped with the current cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].stamp == cyc) begin
                exp_t e;
                logic [31:0] act;
                e = q.pop_front();
                act = get_sig(e.sig);
                total++;
                if (act !== e.val) begin
                    bad++;
                    $display("FAIL %s sig=%0d cycle=%0d actual=%h expected=%h",
                             e.req, e.sig, cyc, act, e.val);
                end
            end
        end
    end

    task automatic ex(int s, logic [31:0] v, string r);
        q.push_back('{cyc, s, v, r});
    endtask

    task automatic nxt();
        @(negedge clk);
        head_miss = 0; miss_arrive = 0; early_en = 0;
        retire_valid = 0; retire_store = 0; retire_rd_we = 0;
        retire_rs1_use = 0; retire_rs2_use = 0;
    endtask

    task automatic ret(input int rd, input bit u1, input int s1, input bit u2,
                       input int s2, input logic [31:0] d, input bit st);
        retire_valid = 1; retire_store = st; retire_rd_we = !st;
        retire_rd = AW'(rd); retire_rs1_use = u1; retire_rs1 = AW'(s1);
        retire_rs2_use = u2; retire_rs2 = AW'(s2); retire_wdata = d;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] d, input bit inv, input string r);
        rf_rd_addr = AW'(a);
        ex(S_RDATA, d, r);
        ex(S_RINV, 32'(inv), r);
    endtask

    task automatic miss(input logic [31:0] pc, input int rd);
        head_miss = 1; head_pc = pc; head_rd = AW'(rd);
    endtask

    initial begin
        head_pc = '0; head_rd = '0; retire_rd = '0; retire_rs1 = '0; retire_rs2 = '0;
        retire_wdata = '0; bhr_in = '0; ras_in = '0; rf_rd_addr = '0;
        nxt(); nxt();
        rst_n = 1;
        // R1 reset state
        nxt();
        ex(S_MODE, 0, "R1"); ex(S_SAVE, 0, "R1"); ex(S_FLUSH, 0, "R1");
        ex(S_FILL, 0, "R1"); ex(S_REDIR, 0, "R1"); ex(S_REST, 0, "R1");
        rd_chk(3, 0, 0, "R1");
        // R11 normal retires
        nxt(); ret(1, 0, 0, 0, 0, 32'h11, 0); ex(S_SKIP, 0, "R11");
        nxt(); ret(2, 1, 1, 0, 0, 32'h22, 0); ex(S_SKIP, 0, "R11");
        nxt(); ret(3, 0, 0, 0, 0, 32'h33, 0);
        nxt(); ret(5, 0, 0, 0, 0, 32'h55, 0);
        nxt(); ret(0, 1, 1, 0, 0, 0, 1); ex(S_STORE, 1, "R5");
        rd_chk(1, 32'h11, 0, "R11");
        // R2 entry
        nxt(); miss(32'h1000, 1); bhr_in = 16'hABCD; ras_in = 32'h55AA;
        ex(S_SAVE, 1, "R2"); ex(S_MODE, 0, "R2");
        nxt(); bhr_in = 16'h0; ras_in = 0;
        ex(S_MODE, 1, "R2"); rd_chk(1, 32'h11, 1, "R2");
        // R3 invalid source
        ret(3, 1, 1, 0, 0, 32'h99, 0); ex(S_SKIP, 1, "R3");
        nxt(); rd_chk(3, 32'h33, 1, "R3");
        ret(4, 0, 0, 1, 2, 32'h44, 0); ex(S_SKIP, 0, "R4");
        nxt(); rd_chk(4, 32'h44, 0, "R4");
        ret(6, 1, 4, 1, 3, 32'h66, 0); ex(S_SKIP, 1, "R3");
        nxt(); rd_chk(6, 0, 1, "R3");
        ret(3, 0, 0, 0, 0, 32'h77, 0); ex(S_SKIP, 0, "R4");
        nxt(); rd_chk(3, 32'h77, 0, "R4");
        ret(0, 1, 2, 0, 0, 0, 1); ex(S_STORE, 0, "R5");
        // R6 second miss
        nxt(); miss(32'h2000, 5); ex(S_SAVE, 0, "R6");
        nxt(); rd_chk(5, 32'h55, 1, "R6"); ex(S_RPC, 32'h1000, "R6");
        // R7 normal exit
        miss_arrive = 1;
        for (int k = 1; k <= LEAD; k++) begin
            nxt(); ex(S_MODE, 1, "R7"); ex(S_FLUSH, 0, "R7"); ex(S_FILL, 0, "R7");
        end
        nxt();
        ex(S_FLUSH, 1, "R7"); ex(S_REDIR, 1, "R7"); ex(S_REST, 1, "R7");
        ex(S_FILL, 1, "R7"); ex(S_RPC, 32'h1000, "R7");
        ex(S_BHR, 32'hABCD, "R7"); ex(S_RAS, 32'h55AA, "R7");
        // R8 restored state
        nxt(); ex(S_MODE, 0, "R8"); rd_chk(1, 32'h11, 0, "R8");
        nxt(); rd_chk(3, 32'h33, 0, "R8");
        nxt(); rd_chk(4, 0, 0, "R8");
        nxt(); rd_chk(5, 32'h55, 0, "R8");
        nxt(); rd_chk(6, 0, 0, "R8");
        // R10 arrival in normal ignored
        miss_arrive = 1;
        for (int k = 0; k < LEAD + 2; k++) begin
            nxt(); ex(S_FLUSH, 0, "R10"); ex(S_MODE, 0, "R10"); ex(S_REDIR, 0, "R10");
        end
        // R9 early restart
        nxt(); miss(32'h3000, 2); bhr_in = 16'h1234; ras_in = 32'h0F0F;
        ex(S_SAVE, 1, "R2");
        nxt(); ret(2, 1, 2, 0, 0, 32'hAA, 0); ex(S_SKIP, 1, "R3");
        nxt(); miss_arrive = 1; early_en = 1; ex(S_MODE, 1, "R9");
        nxt(); ex(S_FLUSH, 1, "R9"); ex(S_REDIR, 1, "R9"); ex(S_FILL, 0, "R9");
        ex(S_RPC, 32'h3000, "R9"); ex(S_BHR, 32'h1234, "R9"); ex(S_RAS, 32'h0F0F, "R9");
        nxt(); ex(S_MODE, 0, "R9"); ex(S_FILL, 0, "R9"); rd_chk(2, 32'h22, 0, "R8");
        for (int k = 2; k < LEAD; k++) begin
            nxt(); ex(S_FILL, 0, "R9"); ex(S_FLUSH, 0, "R9");
        end
        nxt(); ex(S_FILL, 1, "R9"); ex(S_FLUSH, 0, "R9");
        nxt(); ex(S_FILL, 0, "R9"); ex(S_MODE, 0, "R9");
        nxt(); nxt();
        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard left=%0d expected=0", q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule